// File: doc/BRIEF.md
# Two-Port Priority Shared Memory

This block lets two requesters share one synchronous byte-wide memory. A priority port and a secondary port each ask for the memory by pulling an active-low request line. A registered arbiter picks one owner per clock and tells each port that it holds the memory by pulling that port's active-low busy line. The priority port always wins. A secondary request that is waiting gets the memory on the clock edge after the priority port lets go. If the priority port asks again while the secondary port holds the memory, the priority port takes it on the next edge.

A steering stage passes address, write data and write strobe to the array only from the current owner. The priority port gives a plain address, write data and an active-low write strobe. It reads on every cycle in which it owns the memory and does not write. The secondary port uses an enable/acknowledge handshake:

- A select line chooses the access: low means write, high means read.
- The port pulls enable low to start the access.
- The block answers with acknowledge low one edge later.
- For a read, the data is valid while acknowledge is low.

Each port has its own read-data register, so one port's reads never disturb the other's returned data.

Top module: `shmem_ctrl`

## Requirements
- R1: During and after reset, before any request: `pri_busy_n` and `sec_busy_n` are high, `sec_ack_n` is high, and `pri_rdata` and `sec_rdata` are zero.
- R2: A low `pri_req_n` sampled at a rising edge makes `pri_busy_n` low and `sec_busy_n` high after that edge. This holds even when `sec_req_n` is also low.
- R3: At an edge where `pri_req_n` is high and `sec_req_n` is low, `sec_busy_n` goes low. At an edge where both requests are high, both busy lines go high.
- R4: If the priority port raises its request while the secondary request stays low, the owner changes at the next edge: `sec_busy_n` goes low and `pri_busy_n` goes high.
- R5: If the priority port requests while the secondary port owns the memory, the owner changes at the next edge: `pri_busy_n` goes low and `sec_busy_n` goes high.
- R6: While `pri_busy_n` is low, `pri_we_n` low at a rising edge writes `pri_wdata` into word `pri_addr` at that edge.
- R7: While `pri_busy_n` is low and `pri_we_n` is high, `pri_rdata` holds the word at `pri_addr` after each edge (one clock of latency).
- R8: While `sec_busy_n` is low, `sec_en_n` low with `sec_rd_wr` low writes `sec_wdata` into word `sec_addr` at the edge. `sec_ack_n` is low after that edge.
- R9: While `sec_busy_n` is low, `sec_en_n` low with `sec_rd_wr` high makes `sec_ack_n` low after the edge. At the same edge `sec_rdata` becomes the word at `sec_addr`.
- R10: `sec_en_n` high at an edge makes `sec_ack_n` high after that edge.
- R11: An access from a port whose busy line is high is ignored. The memory is not written, and a secondary enable is never acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_req_n | input | 1 | Priority port request, active low |
| pri_busy_n | output | 1 | Priority port grant, low when the port owns the memory |
| pri_addr | input | AW | Priority port word address |
| pri_wdata | input | DW | Priority port write data |
| pri_we_n | input | 1 | Priority port write strobe, active low |
| pri_rdata | output | DW | Priority port registered read data |
| sec_req_n | input | 1 | Secondary port request, active low |
| sec_busy_n | output | 1 | Secondary port grant, low when the port owns the memory |
| sec_addr | input | AW | Secondary port word address |
| sec_wdata | input | DW | Secondary port write data |
| sec_rd_wr | input | 1 | Secondary access select: 0 write, 1 read |
| sec_en_n | input | 1 | Secondary access enable, active low |
| sec_ack_n | output | 1 | Secondary access acknowledge, active low |
| sec_rdata | output | DW | Secondary port registered read data |

## Verification
The bench builds the block with its default 8-bit address and 8-bit data. This keeps the array at 256 words, so every word can be written and read back through both ports. Distinct arithmetic patterns are used for the two ports, so each sweep shows which port last wrote a word. The small array leaves room to walk each grant transition in turn: simultaneous requests, handoff, preemption and idle. Between these transitions the bench makes ignored accesses whose effect would show up in a later read sweep.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_PRI  = 2'd1,
    OWN_SEC  = 2'd2
  } owner_e;
endpackage

// File: rtl/shmem_arbiter.sv
module shmem_arbiter
  import shmem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pri_req_n,
  input  logic   sec_req_n,
  output owner_e owner_q
);
  owner_e owner_d;

  // Strict priority; the result is held for a full clock.
  always_comb begin
    if (!pri_req_n)      owner_d = OWN_PRI;
    else if (!sec_req_n) owner_d = OWN_SEC;
    else                 owner_d = OWN_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_req_n && sec_req_n) |=> (owner_q == OWN_NONE));
endmodule

// File: rtl/shmem_steer.sv
module shmem_steer
  import shmem_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
)(
  input  owner_e        owner,
  input  logic [AW-1:0] pri_addr,
  input  logic [DW-1:0] pri_wdata,
  input  logic          pri_we_n,
  input  logic [AW-1:0] sec_addr,
  input  logic [DW-1:0] sec_wdata,
  input  logic          sec_rd_wr,
  input  logic          sec_en_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          ld_pri,
  output logic          ld_sec
);
  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_we    = 1'b0;
    ld_pri    = 1'b0;
    ld_sec    = 1'b0;
    case (owner)
      OWN_PRI: begin
        mem_addr  = pri_addr;
        mem_wdata = pri_wdata;
        mem_we    = !pri_we_n;
        ld_pri    = pri_we_n;
      end
      OWN_SEC: begin
        mem_addr  = sec_addr;
        mem_wdata = sec_wdata;
        mem_we    = !sec_en_n && !sec_rd_wr;
        ld_sec    = !sec_en_n && sec_rd_wr;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shmem_array.sv
module shmem_array #(
  parameter int AW = 8,
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          ld_pri,
  input  logic          ld_sec,
  output logic [DW-1:0] pri_q,
  output logic [DW-1:0] sec_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] word;
  logic [DW-1:0] pri_d;
  logic [DW-1:0] sec_d;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_comb begin
    word  = mem[addr];
    pri_d = ld_pri ? word : pri_q;
    sec_d = ld_sec ? word : sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
    end else begin
      pri_q <= pri_d;
      sec_q <= sec_d;
    end
  end

  // R11
  no_dual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_pri && ld_sec));
endmodule

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pri_req_n,
  output logic          pri_busy_n,
  input  logic [AW-1:0] pri_addr,
  input  logic [DW-1:0] pri_wdata,
  input  logic          pri_we_n,
  output logic [DW-1:0] pri_rdata,
  input  logic          sec_req_n,
  output logic          sec_busy_n,
  input  logic [AW-1:0] sec_addr,
  input  logic [DW-1:0] sec_wdata,
  input  logic          sec_rd_wr,
  input  logic          sec_en_n,
  output logic          sec_ack_n,
  output logic [DW-1:0] sec_rdata
);
  owner_e        owner_q;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          ld_pri;
  logic          ld_sec;
  logic          ack_d;

  shmem_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .pri_req_n (pri_req_n),
    .sec_req_n (sec_req_n),
    .owner_q   (owner_q)
  );

  shmem_steer #(.AW(AW), .DW(DW)) u_steer (
    .owner     (owner_q),
    .pri_addr  (pri_addr),
    .pri_wdata (pri_wdata),
    .pri_we_n  (pri_we_n),
    .sec_addr  (sec_addr),
    .sec_wdata (sec_wdata),
    .sec_rd_wr (sec_rd_wr),
    .sec_en_n  (sec_en_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .ld_pri    (ld_pri),
    .ld_sec    (ld_sec)
  );

  shmem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (mem_addr),
    .wdata  (mem_wdata),
    .we     (mem_we),
    .ld_pri (ld_pri),
    .ld_sec (ld_sec),
    .pri_q  (pri_rdata),
    .sec_q  (sec_rdata)
  );

  assign pri_busy_n = (owner_q != OWN_PRI);
  assign sec_busy_n = (owner_q != OWN_SEC);

  // Acknowledge: granted enable sampled at an edge.
  always_comb ack_d = !((owner_q == OWN_SEC) && !sec_en_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_ack_n <= 1'b1;
    else        sec_ack_n <= ack_d;
  end

  // R2
  pri_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pri_req_n |=> (!pri_busy_n && sec_busy_n));

  // R4
  sec_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_req_n && !sec_req_n) |=> !sec_busy_n);

  // R10
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_en_n |=> sec_ack_n);

  // R11
  ack_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_ack_n) |-> $past(!sec_busy_n && !sec_en_n));
endmodule

// File: tb/tb_shmem_ctrl.sv
module tb_shmem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pri_req_n, pri_we_n, sec_req_n, sec_rd_wr, sec_en_n;
  logic [AW-1:0] pri_addr, sec_addr;
  logic [DW-1:0] pri_wdata, sec_wdata;
  logic          pri_busy_n, sec_busy_n, sec_ack_n;
  logic [DW-1:0] pri_rdata, sec_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shmem_ctrl #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .pri_req_n(pri_req_n), .pri_busy_n(pri_busy_n), .pri_addr(pri_addr),
    .pri_wdata(pri_wdata), .pri_we_n(pri_we_n), .pri_rdata(pri_rdata),
    .sec_req_n(sec_req_n), .sec_busy_n(sec_busy_n), .sec_addr(sec_addr),
    .sec_wdata(sec_wdata), .sec_rd_wr(sec_rd_wr), .sec_en_n(sec_en_n),
    .sec_ack_n(sec_ack_n), .sec_rdata(sec_rdata)
  );

  function automatic logic [7:0] pat_p(int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  function automatic logic [7:0] pat_s(int a);
    return 8'(a) ^ 8'h5C;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pri_req_n = 1'b1; pri_we_n = 1'b1; pri_addr = '0; pri_wdata = '0;
    sec_req_n = 1'b1; sec_rd_wr = 1'b1; sec_en_n = 1'b1;
    sec_addr = '0; sec_wdata = '0;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 pri_busy", pri_busy_n, 1);
    chk("R1 sec_busy", sec_busy_n, 1);
    chk("R1 ack", sec_ack_n, 1);
    chk("R1 pri_rdata", pri_rdata, 0);
    chk("R1 sec_rdata", sec_rdata, 0);

    // R2 priority grant
    pri_req_n = 1'b0;
    step();
    chk("R2 pri_busy", pri_busy_n, 0);
    chk("R2 sec_busy", sec_busy_n, 1);

    // R6 priority write sweep
    for (int a = 0; a < N; a++) begin
      pri_addr = 8'(a); pri_wdata = pat_p(a); pri_we_n = 1'b0;
      step();
    end
    pri_we_n = 1'b1;
    // R7 priority read sweep (checks R6 contents)
    for (int a = 0; a < N; a++) begin
      pri_addr = 8'(a);
      step();
      chk("R7 R6 pri read", pri_rdata, pat_p(a));
    end

    // R2 both requesting: secondary waits
    sec_req_n = 1'b0;
    step();
    chk("R2 both pri_busy", pri_busy_n, 0);
    chk("R2 both sec_busy", sec_busy_n, 1);
    // R11 ungranted secondary write
    sec_addr = 8'd5; sec_wdata = 8'hAA; sec_rd_wr = 1'b0; sec_en_n = 1'b0;
    step();
    chk("R11 no ack", sec_ack_n, 1);
    sec_en_n = 1'b1; sec_rd_wr = 1'b1;

    // R4 handoff on release
    pri_req_n = 1'b1;
    step();
    chk("R4 sec_busy", sec_busy_n, 0);
    chk("R4 pri_busy", pri_busy_n, 1);

    // R9 read of word 5: must still hold priority pattern (R11)
    sec_addr = 8'd5; sec_rd_wr = 1'b1; sec_en_n = 1'b0;
    step();
    chk("R9 ack", sec_ack_n, 0);
    chk("R11 word5 kept", sec_rdata, pat_p(5));
    sec_en_n = 1'b1;
    step();
    chk("R10 ack high", sec_ack_n, 1);

    // R8 secondary write sweep
    for (int a = 0; a < N; a++) begin
      sec_addr = 8'(a); sec_wdata = pat_s(a); sec_rd_wr = 1'b0; sec_en_n = 1'b0;
      step();
      chk("R8 ack", sec_ack_n, 0);
      sec_en_n = 1'b1;
      step();
      chk("R10 ack", sec_ack_n, 1);
    end
    // R9 secondary read sweep
    sec_rd_wr = 1'b1;
    for (int a = 0; a < N; a++) begin
      sec_addr = 8'(a); sec_en_n = 1'b0;
      step();
      chk("R9 ack", sec_ack_n, 0);
      chk("R9 R8 sec read", sec_rdata, pat_s(a));
      sec_en_n = 1'b1;
      step();
    end

    // R11 ungranted priority write
    pri_addr = 8'd9; pri_wdata = 8'h11; pri_we_n = 1'b0;
    step();
    pri_we_n = 1'b1;

    // R5 preemption
    pri_req_n = 1'b0;
    step();
    chk("R5 pri_busy", pri_busy_n, 0);
    chk("R5 sec_busy", sec_busy_n, 1);
    for (int a = 0; a < N; a++) begin
      pri_addr = 8'(a);
      step();
      chk("R7 R11 pri read", pri_rdata, pat_s(a));
    end

    // R3 idle then secondary alone
    pri_req_n = 1'b1; sec_req_n = 1'b1;
    step();
    chk("R3 idle pri", pri_busy_n, 1);
    chk("R3 idle sec", sec_busy_n, 1);
    sec_req_n = 1'b0;
    step();
    chk("R3 sec grant", sec_busy_n, 0);
    chk("R3 pri stays", pri_busy_n, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule